// File: doc/BRIEF.md
# Posted-CAS Read/Write Latency Scheduler

This block sits on the controller side of a double-data-rate memory interface. Read and write column commands are posted right after activate, and the block works out when the matching data must appear on the bus. It produces registered, cycle-exact enables for the data path: a read-capture window and a write-drive window, each paired with a strobe-enable that opens one cycle early to cover the strobe preamble.

Timing comes from three settings loaded through a small configuration port: CAS latency, additive latency and burst length. Read latency (RL) is the sum of CAS and additive latency. Write latency (WL) is RL minus one. Data moves on both clock edges, so a 4-word burst fills two clock cycles and an 8-word burst fills four. Pending commands travel down a shift pipeline, so commands spaced by exactly the burst duration give one unbroken window. Settings can change only while nothing is in flight. A read posted while a write burst is still pending or driving is refused and flagged.

Top module: `pcas_lat_sched`

## Requirements
- R1: A read accepted at clock edge k drives rd_capture high from edge k+RL up to edge k+RL+B. RL = CL + AL, and B is the burst length in clock cycles.
- R2: A write accepted at clock edge k drives wr_drive high from edge k+WL up to edge k+WL+B, where WL = RL - 1.
- R3: When cfg_burst8 is 0 a burst lasts B = 2 clock cycles (4 words). When cfg_burst8 is 1 it lasts B = 4 clock cycles (8 words).
- R4: Each strobe enable rises exactly one cycle before its data window opens, and it falls in the same cycle as that window. A data window is never high while its strobe enable is low.
- R5: Two commands of the same kind spaced exactly B cycles apart produce one contiguous window, 2B cycles long, with no gap.
- R6: A cfg_req while any command is in flight is not applied, and cfg_busy is high in the next cycle. A cfg_req while the pipeline is empty is applied at that edge, and a command sampled at the same edge uses the new settings.
- R7: cfg_cas_lat and cfg_add_lat are binary cycle counts. A request with a CAS latency outside 3..5, or an additive latency above 4, is ignored and the previous settings remain in force.
- R8: A read sampled while an earlier write has not yet finished its drive window is dropped. No window is produced for it, and turn_err is high for exactly the next cycle. A read that arrives WL+B or more cycles after a write is accepted.
- R9: A synchronous reset clears every pending command and sets all window outputs, cfg_busy and turn_err low. It also restores CAS latency 3, additive latency 0 and 4-word bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A column command is present this cycle |
| cmd_is_wr | input | 1 | 1 = write command, 0 = read command |
| cfg_req | input | 1 | Request to load new latency settings |
| cfg_cas_lat | input | 3 | Requested CAS latency in cycles (3..5) |
| cfg_add_lat | input | 3 | Requested additive latency in cycles (0..4) |
| cfg_burst8 | input | 1 | 1 = 8-word bursts, 0 = 4-word bursts |
| rd_capture | output | 1 | Read data capture window |
| rd_strobe_en | output | 1 | Read strobe enable, includes preamble cycle |
| wr_drive | output | 1 | Write data drive window |
| wr_strobe_en | output | 1 | Write strobe enable, includes preamble cycle |
| cfg_busy | output | 1 | Previous configuration request was refused (in flight) |
| turn_err | output | 1 | Previous read was dropped because of write turnaround |

## Verification
The assertions check, on every cycle, the rules that hold no matter what the settings are:
- each data window lies inside its strobe enable, and each strobe opens one cycle before its data;
- settings stay fixed while a refusal is flagged, and only legal values are ever held;
- cfg_busy and turn_err always trace back to a request or a read one cycle earlier;
- outputs are low right after reset.

The exact opening cycle for each CL/AL/burst combination cannot be seen by any property over ports, and neither can window merging, the accept/reject boundary for a read after a write, or the restored reset settings. Only the bench's scenarios show these, by comparing whole traces against latencies computed from the settings.

// File: rtl/pcas_lat_pkg.sv
package pcas_lat_pkg;

  localparam int CL_MIN = 3;
  localparam int CL_MAX = 5;
  localparam int AL_MAX = 4;
  localparam int LANES  = 2;   // lane 0 = read, lane 1 = write

  typedef struct packed {
    logic [2:0] cl;
    logic [2:0] al;
    logic       bl8;
  } lat_cfg_t;

  function automatic logic cfg_is_legal(input lat_cfg_t c);
    return (int'(c.cl) >= CL_MIN) && (int'(c.cl) <= CL_MAX) &&
           (int'(c.al) <= AL_MAX);
  endfunction

endpackage

// File: rtl/pcas_cfg_reg.sv
module pcas_cfg_reg
  import pcas_lat_pkg::*;
#(
  parameter int CL_RST = 3,
  parameter int AL_RST = 0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     req,
  input  lat_cfg_t req_cfg,
  input  logic     pipe_empty,
  output lat_cfg_t cfg_q,
  output logic     busy_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.cl  <= 3'(CL_RST);
      cfg_q.al  <= 3'(AL_RST);
      cfg_q.bl8 <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      busy_q <= req && !pipe_empty;
      if (req && pipe_empty && cfg_is_legal(req_cfg))
        cfg_q <= req_cfg;
    end
  end

endmodule

// File: rtl/pcas_cmd_pipe.sv
module pcas_cmd_pipe #(
  parameter int DEPTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  output logic [DEPTH-1:0] stages
);

  // stages[i] set: a command was accepted i+1 edges ago
  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= {stages[DEPTH-2:0], push};
  end

endmodule

// File: rtl/pcas_win_gen.sv
module pcas_win_gen #(
  parameter int DEPTH = 12,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] stages,
  input  logic [LAT_W-1:0] lat,
  input  logic [2:0]       bcyc,
  output logic             data_q,
  output logic             strobe_q
);

  int   first_idx;
  int   last_idx;
  logic data_d;
  logic strobe_d;

  assign first_idx = int'(lat) - 1;
  assign last_idx  = int'(lat) + int'(bcyc) - 2;

  always_comb begin
    data_d   = 1'b0;
    strobe_d = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (stages[i] && (i >= first_idx) && (i <= last_idx))
        data_d = 1'b1;
      if (stages[i] && (i >= first_idx - 1) && (i <= last_idx))
        strobe_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      data_q   <= data_d;
      strobe_q <= strobe_d;
    end
  end

endmodule

// File: rtl/pcas_lat_sched.sv
module pcas_lat_sched
  import pcas_lat_pkg::*;
#(
  parameter int DEPTH  = 12,
  parameter int CL_RST = 3,
  parameter int AL_RST = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic       cmd_is_wr,
  input  logic       cfg_req,
  input  logic [2:0] cfg_cas_lat,
  input  logic [2:0] cfg_add_lat,
  input  logic       cfg_burst8,
  output logic       rd_capture,
  output logic       rd_strobe_en,
  output logic       wr_drive,
  output logic       wr_strobe_en,
  output logic       cfg_busy,
  output logic       turn_err
);

  localparam int LAT_W = $clog2(DEPTH + 1);

  lat_cfg_t         req_cfg;
  lat_cfg_t         cfg_q;
  logic [LAT_W-1:0] rd_lat;
  logic [2:0]       bcyc;
  logic             pipe_empty;
  logic             wr_active;
  logic             rd_refused;
  int               wr_last_idx;

  logic [LANES-1:0] lane_push;
  logic [DEPTH-1:0] lane_stages [LANES];
  logic [LAT_W-1:0] lane_lat    [LANES];
  logic [LANES-1:0] lane_data;
  logic [LANES-1:0] lane_strobe;

  assign req_cfg.cl  = cfg_cas_lat;
  assign req_cfg.al  = cfg_add_lat;
  assign req_cfg.bl8 = cfg_burst8;

  pcas_cfg_reg #(
    .CL_RST (CL_RST),
    .AL_RST (AL_RST)
  ) cfg_i (
    .clk        (clk),
    .rst        (rst),
    .req        (cfg_req),
    .req_cfg    (req_cfg),
    .pipe_empty (pipe_empty),
    .cfg_q      (cfg_q),
    .busy_q     (cfg_busy)
  );

  assign rd_lat = LAT_W'(cfg_q.cl) + LAT_W'(cfg_q.al);
  assign bcyc   = cfg_q.bl8 ? 3'd4 : 3'd2;

  assign lane_lat[0] = rd_lat;
  assign lane_lat[1] = rd_lat - LAT_W'(1);

  // a write is still live until its drive window has closed
  assign wr_last_idx = int'(lane_lat[1]) + int'(bcyc) - 2;
  always_comb begin
    wr_active = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (lane_stages[1][i] && (i <= wr_last_idx)) wr_active = 1'b1;
  end

  assign rd_refused   = cmd_valid && !cmd_is_wr && wr_active;
  assign lane_push[0] = cmd_valid && !cmd_is_wr && !wr_active;
  assign lane_push[1] = cmd_valid && cmd_is_wr;

  always_ff @(posedge clk) begin
    if (rst) turn_err <= 1'b0;
    else     turn_err <= rd_refused;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pcas_cmd_pipe #(.DEPTH(DEPTH)) pipe_i (
      .clk    (clk),
      .rst    (rst),
      .push   (lane_push[g]),
      .stages (lane_stages[g])
    );
    pcas_win_gen #(.DEPTH(DEPTH), .LAT_W(LAT_W)) win_i (
      .clk      (clk),
      .rst      (rst),
      .stages   (lane_stages[g]),
      .lat      (lane_lat[g]),
      .bcyc     (bcyc),
      .data_q   (lane_data[g]),
      .strobe_q (lane_strobe[g])
    );
  end

  assign pipe_empty = ~|{lane_stages[0], lane_stages[1]};

  assign rd_capture   = lane_data[0];
  assign rd_strobe_en = lane_strobe[0];
  assign wr_drive     = lane_data[1];
  assign wr_strobe_en = lane_strobe[1];

endmodule

// File: rtl/pcas_lat_sched_chk.sv
module pcas_lat_sched_chk
  import pcas_lat_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     cmd_valid,
  input logic     cmd_is_wr,
  input logic     cfg_req,
  input logic     rd_capture,
  input logic     rd_strobe_en,
  input logic     wr_drive,
  input logic     wr_strobe_en,
  input logic     cfg_busy,
  input logic     turn_err,
  input lat_cfg_t cur_cfg
);

  AST_RD_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    rd_capture |-> rd_strobe_en); // R4
  AST_WR_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    wr_drive |-> wr_strobe_en); // R4
  AST_RD_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_strobe_en) |-> !rd_capture ##1 rd_capture); // R4
  AST_WR_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_strobe_en) |-> !wr_drive ##1 wr_drive); // R4
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    cfg_busy |-> $stable(cur_cfg)); // R6
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cfg_busy |-> $past(cfg_req)); // R6
  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cfg_is_legal(cur_cfg)); // R7
  AST_TURN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    turn_err |-> $past(cmd_valid && !cmd_is_wr)); // R8
  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(rd_capture || rd_strobe_en || wr_drive ||
                     wr_strobe_en || cfg_busy || turn_err)); // R9

endmodule

bind pcas_lat_sched pcas_lat_sched_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_is_wr    (cmd_is_wr),
  .cfg_req      (cfg_req),
  .rd_capture   (rd_capture),
  .rd_strobe_en (rd_strobe_en),
  .wr_drive     (wr_drive),
  .wr_strobe_en (wr_strobe_en),
  .cfg_busy     (cfg_busy),
  .turn_err     (turn_err),
  .cur_cfg      (cfg_q)
);

// File: tb/pcas_lat_sched_tb.sv
`timescale 1ns/1ps
module pcas_lat_sched_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_is_wr = 1'b0;
  logic       cfg_req = 1'b0;
  logic [2:0] cfg_cas_lat = 3'd3;
  logic [2:0] cfg_add_lat = 3'd0;
  logic       cfg_burst8 = 1'b0;
  logic       rd_capture, rd_strobe_en, wr_drive, wr_strobe_en;
  logic       cfg_busy, turn_err;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  // bench model of the settings in force
  int  m_cl = 3, m_al = 0, m_b = 2;

  always #2.5 clk = ~clk;

  pcas_lat_sched dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
    .cfg_req(cfg_req), .cfg_cas_lat(cfg_cas_lat), .cfg_add_lat(cfg_add_lat),
    .cfg_burst8(cfg_burst8), .rd_capture(rd_capture),
    .rd_strobe_en(rd_strobe_en), .wr_drive(wr_drive),
    .wr_strobe_en(wr_strobe_en), .cfg_busy(cfg_busy), .turn_err(turn_err)
  );

  typedef struct packed {
    logic [2:0] cl;
    logic [2:0] al;
    logic       bl8;
    logic       wr;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{3'd3, 3'd0, 1'b0, 1'b0},
    '{3'd4, 3'd4, 1'b1, 1'b0},
    '{3'd5, 3'd4, 1'b1, 1'b1},
    '{3'd3, 3'd0, 1'b0, 1'b1},
    '{3'd5, 3'd2, 1'b0, 1'b0},
    '{3'd4, 3'd1, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit in_win(input int n, input int t, input int lat,
                                input int b, input bit strobe);
    int lo = t + lat - (strobe ? 1 : 0);
    return (n >= lo) && (n <= t + lat + b - 1);
  endfunction

  task automatic apply_cfg(input int cl, input int al, input bit bl8);
    @(negedge clk);
    cfg_req = 1'b1; cfg_cas_lat = 3'(cl); cfg_add_lat = 3'(al); cfg_burst8 = bl8;
    @(negedge clk);
    cfg_req = 1'b0;
    check(cfg_busy == 1'b0, "R6", "busy on idle request", cfg_busy, 0);
    if (cl >= 3 && cl <= 5 && al >= 0 && al <= 4) begin
      m_cl = cl; m_al = al; m_b = bl8 ? 4 : 2;
    end
  endtask

  // first command at edge k, optional second command g edges later
  task automatic run_scen(input string tag, input bit w0, input bit has1,
                          input bit w1, input int g);
    int rl = m_cl + m_al;
    int wl = rl - 1;
    bit acc1 = has1 && !(w0 && !w1 && g < wl + m_b);
    int bad [5];
    int bn [5];
    logic ba [5];
    logic act [5];
    logic exp [5];
    string nm [5] = '{"rd_capture", "rd_strobe_en", "wr_drive",
                      "wr_strobe_en", "turn_err"};
    for (int s = 0; s < 5; s++) begin bad[s] = 0; bn[s] = 0; ba[s] = 0; end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_wr = w0;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int n = 0; n < 28; n++) begin
      act = '{rd_capture, rd_strobe_en, wr_drive, wr_strobe_en, turn_err};
      for (int s = 0; s < 4; s++) begin
        bit wsig = (s >= 2);
        bit strb = (s % 2 == 1);
        int lat  = wsig ? wl : rl;
        exp[s] = ((w0 == wsig) && in_win(n, 0, lat, m_b, strb)) ||
                 (acc1 && (w1 == wsig) && in_win(n, g, lat, m_b, strb));
      end
      exp[4] = has1 && !acc1 && (n == g);
      for (int s = 0; s < 5; s++)
        if (act[s] !== exp[s]) begin
          if (bad[s] == 0) begin bn[s] = n; ba[s] = act[s]; end
          bad[s]++;
        end
      if (has1 && (n + 1 == g)) begin cmd_valid = 1'b1; cmd_is_wr = w1; end
      else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    for (int s = 0; s < 5; s++) begin
      string t = (s == 4) ? "R8" : ((s % 2 == 1) ? {tag, " R4"} : tag);
      check(bad[s] == 0, t, $sformatf("%s at cycle %0d", nm[s], bn[s]),
            int'(ba[s]), int'(!ba[s]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state of every output
    check({rd_capture, rd_strobe_en, wr_drive, wr_strobe_en, cfg_busy, turn_err} == 6'b0,
          "R9", "outputs after reset",
          int'({rd_capture, rd_strobe_en, wr_drive, wr_strobe_en, cfg_busy, turn_err}), 0);
    // R9: default settings CL3 AL0 burst 4
    run_scen("R9", 1'b0, 1'b0, 1'b0, 1);

    // R1 R2 R3: table walk over settings and command kinds
    for (int v = 0; v < 6; v++) begin
      apply_cfg(int'(VECS[v].cl), int'(VECS[v].al), VECS[v].bl8);
      run_scen(VECS[v].wr ? "R2 R3" : "R1 R3", VECS[v].wr, 1'b0, 1'b0, 1);
    end

    // R5: gapless back-to-back bursts
    apply_cfg(3, 0, 1'b1);
    run_scen("R5", 1'b0, 1'b1, 1'b0, 4);
    apply_cfg(4, 2, 1'b0);
    run_scen("R5", 1'b1, 1'b1, 1'b1, 2);

    // R8: read after write, refused inside window and accepted at boundary
    apply_cfg(3, 1, 1'b0);
    run_scen("R8", 1'b1, 1'b1, 1'b0, 2);
    run_scen("R8", 1'b1, 1'b1, 1'b0, 5);
    run_scen("R8", 1'b0, 1'b1, 1'b1, 1);

    // R6: request while a read is in flight is refused
    apply_cfg(3, 0, 1'b0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_wr = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    cfg_req = 1'b1; cfg_cas_lat = 3'd5; cfg_add_lat = 3'd4; cfg_burst8 = 1'b1;
    @(negedge clk);
    cfg_req = 1'b0;
    check(cfg_busy == 1'b1, "R6", "busy on in-flight request", cfg_busy, 1);
    @(negedge clk);
    check(cfg_busy == 1'b0, "R6", "busy clears", cfg_busy, 0);
    repeat (16) @(negedge clk);
    run_scen("R6", 1'b0, 1'b0, 1'b0, 1);

    // R7: illegal values are ignored
    apply_cfg(6, 0, 1'b1);
    run_scen("R7", 1'b0, 1'b0, 1'b0, 1);
    apply_cfg(4, 5, 1'b1);
    run_scen("R7", 1'b1, 1'b0, 1'b0, 1);

    // R9: reset in the middle of a burst
    apply_cfg(5, 4, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_wr = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (9) @(negedge clk);
    check(rd_capture == 1'b1, "R9", "window open before reset", rd_capture, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    begin
      int seen = 0;
      for (int n = 0; n < 16; n++) begin
        if (rd_capture || rd_strobe_en || wr_drive || wr_strobe_en) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R9", "window cycles after reset", seen, 0);
    end
    m_cl = 3; m_al = 0; m_b = 2;
    run_scen("R9", 1'b1, 1'b0, 1'b0, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule